// File: doc/BRIEF.md
# Doubleword Atomic Memory Operation Sequencer

This unit carries out one 64-bit atomic read-modify-write on behalf of a RISC-V style integer pipeline. The pipeline hands it a 32-bit instruction word and the two source register values while the unit reports itself ready. The unit decodes the operation from the instruction and reads the doubleword at the address held in the first source value. It combines that loaded value with the second source value and writes the combined value back to the same address. The original loaded value goes to the destination register.

Memory traffic uses a single-outstanding handshake. A request is held until it is granted, and each granted request is answered later by one response pulse, which carries the read data for reads. The unit is busy from acceptance until it returns to idle. It ignores any other offer while busy. A finished operation shows up as a one-cycle completion pulse carrying the register writeback strobe, the register index and the data. An operation code outside the supported set ends in an error pulse and makes no memory access. Ordering hints carried in the instruction are not acted on.

Top module: `amo_unit`

## Requirements
- R1: An offered instruction is taken only when the unit is ready, bits [6:0] equal 0101111 and bits [14:12] equal 011. Any other offer is ignored: no memory request, no completion pulse, and the unit stays ready.
- R2: From acceptance until it returns to idle, busy_o is high and issue_ready_o is low, and further offers are ignored.
- R3: The read and the write both use the whole first source value as address. The read comes first and the write follows its response. Each request holds its address, direction and write data steady until granted.
- R4: The completion pulse carries rd_we_o with rd_addr_o equal to bits [11:7]. It returns on rd_data_o the doubleword that memory held before the operation.
- R5: When bits [11:7] are zero, rd_we_o stays low, and the memory update still takes place.
- R6: Operation code (bits [31:27]) 00001 stores the second source value. Code 00000 stores the old value plus the second source value, modulo 2^64.
- R7: Code 00100 stores old XOR source, 01100 stores old AND source, and 01000 stores old OR source.
- R8: Code 10000 stores the smaller and 10100 the larger of old and source, both compared as signed two's-complement numbers.
- R9: Code 11000 stores the smaller and 11100 the larger of old and source, both compared as unsigned numbers.
- R10: Any other operation code with a matching opcode and width field gives illegal_o together with done_o, with rd_we_o low and no memory request at all.
- R11: While rst_ni is low, and right after it is released, the unit is idle. In that state issue_ready_o is high, and busy_o, mem_req_o, done_o, rd_we_o and illegal_o are low.
- R12: done_o is high for exactly one cycle for each accepted instruction. Bits 26 and 25 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction offered |
| issue_ready_o | output | 1 | Unit idle and able to take an instruction |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | First source value (address) |
| rs2_val_i | input | 64 | Second source value (operand) |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Request address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted by memory |
| mem_rvalid_i | input | 1 | Response for the accepted request |
| mem_rdata_i | input | 64 | Read data, valid with the response |
| done_o | output | 1 | Completion pulse |
| rd_we_o | output | 1 | Destination register write enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Old memory value for the register file |
| illegal_o | output | 1 | Unsupported operation code, with done_o |

## Verification
The bound checker watches the handshake rules on every cycle. A pending request must keep its address, direction and write data until granted. The completion pulse lasts one cycle, and the writeback strobe appears only with the completion pulse and never for register zero. The error flag comes without a writeback, and the unit only turns busy after an offer. Only the bench scenarios can show the data results. These are the stored value for each of the nine codes, the signed and unsigned comparison corners and the wrap of the add. The scenarios also cover the silent handling of non-matching offers and of offers made while busy, and the absence of any memory access for an unsupported code.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [6:0] OPC_AMO   = 7'b0101111;
  localparam logic [2:0] WIDTH_DW  = 3'b011;

  typedef enum logic [3:0] {
    OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
    OP_MIN, OP_MAX, OP_MINU, OP_MAXU
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_DONE
  } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        match_o,
  output logic        legal_o,
  output amo_op_e     op_o,
  output logic [4:0]  rd_o
);
  logic [4:0] f5;
  logic       unused_hint;

  assign f5          = instr_i[31:27];
  assign rd_o        = instr_i[11:7];
  assign match_o     = (instr_i[6:0] == OPC_AMO) && (instr_i[14:12] == WIDTH_DW);
  // ordering hints and register indices other than rd are not used here
  assign unused_hint = ^instr_i[26:15];

  always_comb begin
    legal_o = 1'b1;
    op_o    = OP_SWAP;
    unique case (f5)
      5'b00001: op_o = OP_SWAP;
      5'b00000: op_o = OP_ADD;
      5'b00100: op_o = OP_XOR;
      5'b01100: op_o = OP_AND;
      5'b01000: op_o = OP_OR;
      5'b10000: op_o = OP_MIN;
      5'b10100: op_o = OP_MAX;
      5'b11000: op_o = OP_MINU;
      5'b11100: op_o = OP_MAXU;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] opnd_i,
  input  amo_op_e         op_i,
  output logic [XLEN-1:0] result_o
);
  localparam int unsigned CW = XLEN + 1;

  logic          is_signed;
  logic [CW-1:0] ext_old, ext_opnd, diff;
  logic          old_lt;

  assign is_signed = (op_i == OP_MIN) || (op_i == OP_MAX);
  // one shared subtractor: extension bit picks signed or unsigned order
  assign ext_old  = {is_signed & old_i[XLEN-1],  old_i};
  assign ext_opnd = {is_signed & opnd_i[XLEN-1], opnd_i};
  assign diff     = ext_old - ext_opnd;
  assign old_lt   = diff[CW-1];

  always_comb begin
    unique case (op_i)
      OP_SWAP: result_o = opnd_i;
      OP_ADD:  result_o = old_i + opnd_i;
      OP_XOR:  result_o = old_i ^ opnd_i;
      OP_AND:  result_o = old_i & opnd_i;
      OP_OR:   result_o = old_i | opnd_i;
      OP_MIN,
      OP_MINU: result_o = old_lt ? old_i : opnd_i;
      OP_MAX,
      OP_MAXU: result_o = old_lt ? opnd_i : old_i;
      default: result_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            legal_i,
  input  amo_op_e         op_i,
  input  logic [RW-1:0]   rd_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic            gnt_i,
  input  logic            rvalid_i,
  input  logic [XLEN-1:0] rdata_i,
  output amo_state_e      state_o,
  output amo_op_e         op_o,
  output logic [RW-1:0]   rd_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] opnd_o,
  output logic [XLEN-1:0] old_o,
  output logic            illegal_o
);
  amo_state_e      state_q, state_d;
  amo_op_e         op_q;
  logic [RW-1:0]   rd_q;
  logic [XLEN-1:0] addr_q, opnd_q, old_q;
  logic            ill_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (take_i)   state_d = legal_i ? ST_RD_REQ : ST_DONE;
      ST_RD_REQ:  if (gnt_i)    state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rvalid_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (gnt_i)    state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (rvalid_i) state_d = ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SWAP;
      rd_q    <= '0;
      addr_q  <= '0;
      opnd_q  <= '0;
      old_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && take_i) begin
        op_q   <= op_i;
        rd_q   <= rd_i;
        addr_q <= addr_i;
        opnd_q <= opnd_i;
        old_q  <= '0;
        ill_q  <= !legal_i;
      end
      if (state_q == ST_RD_WAIT && rvalid_i) old_q <= rdata_i;
    end
  end

  assign state_o   = state_q;
  assign op_o      = op_q;
  assign rd_o      = rd_q;
  assign addr_o    = addr_q;
  assign opnd_o    = opnd_q;
  assign old_o     = old_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  output logic            issue_ready_o,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            done_o,
  output logic            rd_we_o,
  output logic [RW-1:0]   rd_addr_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            illegal_o
);
  logic            dec_match, dec_legal, take, seq_ill;
  amo_op_e         dec_op, seq_op;
  logic [4:0]      dec_rd;
  logic [RW-1:0]   seq_rd;
  logic [XLEN-1:0] seq_addr, seq_opnd, seq_old, alu_res;
  amo_state_e      state;

  amo_decode u_dec (
    .instr_i (instr_i),
    .match_o (dec_match),
    .legal_o (dec_legal),
    .op_o    (dec_op),
    .rd_o    (dec_rd)
  );

  assign take = issue_valid_i && dec_match;

  amo_seq #(.XLEN(XLEN), .RW(RW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .legal_i   (dec_legal),
    .op_i      (dec_op),
    .rd_i      (dec_rd[RW-1:0]),
    .addr_i    (rs1_val_i),
    .opnd_i    (rs2_val_i),
    .gnt_i     (mem_gnt_i),
    .rvalid_i  (mem_rvalid_i),
    .rdata_i   (mem_rdata_i),
    .state_o   (state),
    .op_o      (seq_op),
    .rd_o      (seq_rd),
    .addr_o    (seq_addr),
    .opnd_o    (seq_opnd),
    .old_o     (seq_old),
    .illegal_o (seq_ill)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .old_i    (seq_old),
    .opnd_i   (seq_opnd),
    .op_i     (seq_op),
    .result_o (alu_res)
  );

  assign issue_ready_o = (state == ST_IDLE);
  assign busy_o        = (state != ST_IDLE);
  assign mem_req_o     = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_we_o      = (state == ST_WR_REQ);
  assign mem_addr_o    = seq_addr;
  assign mem_wdata_o   = alu_res;
  assign done_o        = (state == ST_DONE);
  assign rd_we_o       = done_o && !seq_ill && (seq_rd != '0);
  assign rd_addr_o     = seq_rd;
  assign rd_data_o     = seq_old;
  assign illegal_o     = done_o && seq_ill;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_valid_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_gnt_i,
  input logic            done_o,
  input logic            rd_we_o,
  input logic [RW-1:0]   rd_addr_o,
  input logic            illegal_o
);
  p_take_after_offer_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(issue_valid_i));

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));

  p_wdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_gnt_i |=> $stable(mem_wdata_o));

  p_we_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> done_o);

  p_no_x0_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> rd_addr_o != '0);

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !rd_we_o && !mem_req_o);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .RW(RW)) u_chk (.*);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs1_val = '0, rs2_val = '0;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        issue_ready, busy, mem_req, mem_we, done, rd_we, illegal;
  logic [63:0] mem_addr, mem_wdata, rd_data;
  logic [4:0]  rd_addr;

  always #5 clk = ~clk;

  amo_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .instr_i(instr), .rs1_val_i(rs1_val), .rs2_val_i(rs2_val), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .rd_we_o(rd_we), .rd_addr_o(rd_addr), .rd_data_o(rd_data),
    .illegal_o(illegal)
  );

  localparam logic [63:0] BASE = 64'h8000_0000_0000_0100;

  int checks = 0, errs = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [63:0] mem [16];
  int  stall_cfg = 0, rsp_cfg = 0, wait_cnt = 0, rsp_cnt = 0, gnt_count = 0, done_count = 0;
  bit  pending = 0;
  logic [63:0] rd_seen, wr_seen;

  always @(negedge clk) begin
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    if (!rst_n) begin
      pending  = 0;
      wait_cnt = 0;
    end else if (pending) begin
      if (rsp_cnt == 0) begin
        mem_rvalid = 1'b1;
        pending    = 0;
      end else rsp_cnt--;
    end else if (mem_req) begin
      if (wait_cnt >= stall_cfg) begin
        mem_gnt  = 1'b1;
        wait_cnt = 0;
        gnt_count++;
        pending  = 1;
        rsp_cnt  = rsp_cfg;
        if (mem_we) begin
          mem[mem_addr[6:3]] = mem_wdata;
          wr_seen = mem_addr;
        end else begin
          mem_rdata = mem[mem_addr[6:3]];
          rd_seen   = mem_addr;
        end
      end else wait_cnt++;
    end
  end

  typedef struct {
    bit          we;
    logic [4:0]  rd;
    logic [63:0] old;
    bit          ill;
    int          idx;
    logic [63:0] newv;
    logic [63:0] addr;
    int          grants;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [63:0] model(input logic [4:0] f5, input logic [63:0] o,
                                        input logic [63:0] s, output bit ok);
    ok = 1;
    case (f5)
      5'b00001: return s;
      5'b00000: return o + s;
      5'b00100: return o ^ s;
      5'b01100: return o & s;
      5'b01000: return o | s;
      5'b10000: return ($signed(o) < $signed(s)) ? o : s;
      5'b10100: return ($signed(o) > $signed(s)) ? o : s;
      5'b11000: return (o < s) ? o : s;
      5'b11100: return (o > s) ? o : s;
      default: begin ok = 0; return o; end
    endcase
  endfunction

  task automatic do_amo(input logic [4:0] f5, input logic [4:0] rd, input int idx,
                        input logic [63:0] opnd, input string tag,
                        input logic [1:0] hints = 2'b00, input int hold = 1);
    exp_t e;
    bit ok;
    while (!issue_ready) @(negedge clk);
    e.addr = BASE | (64'(idx) << 3);
    e.idx  = idx;
    e.old  = mem[idx];
    e.newv = model(f5, mem[idx], opnd, ok);
    e.ill  = !ok;
    e.we   = ok && (rd != 0);
    e.rd   = rd;
    e.grants = ok ? 2 : 0;
    e.tag  = tag;
    q.push_back(e);
    gnt_count   = 0;
    instr       = {f5, hints, 5'd7, 5'd3, 3'b011, rd, 7'b0101111};
    rs1_val     = e.addr;
    rs2_val     = opnd;
    issue_valid = 1'b1;
    repeat (hold) @(negedge clk);
    issue_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_count++;
      if (q.size() == 0) check(0, "R2 R12 unexpected completion", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(rd_we == e.we, {e.tag, " R4 R5 rd_we"}, 64'(rd_we), 64'(e.we));
        check(illegal == e.ill, {e.tag, " R10 illegal"}, 64'(illegal), 64'(e.ill));
        if (e.we) begin
          check(rd_addr == e.rd, {e.tag, " R4 rd_addr"}, 64'(rd_addr), 64'(e.rd));
          check(rd_data == e.old, {e.tag, " R4 rd_data"}, rd_data, e.old);
        end
        check(mem[e.idx] == e.newv, {e.tag, " stored value"}, mem[e.idx], e.newv);
        check(gnt_count == e.grants, {e.tag, " R3 R10 access count"}, 64'(gnt_count), 64'(e.grants));
        if (!e.ill) begin
          check(rd_seen == e.addr, {e.tag, " R3 read address"}, rd_seen, e.addr);
          check(wr_seen == e.addr, {e.tag, " R3 write address"}, wr_seen, e.addr);
        end
      end
    end
  end

  // R12: done never on two consecutive cycles
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done_prev && done) check(0, "R12 done width", 64'd2, 64'd1);
    done_prev = done;
  end

  bit finished = 0;
  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'h1111_0000_0000_0000 + 64'(i);
    mem[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    mem[6] = 64'd5;
    mem[7] = 64'hFFFF_FFFF_FFFF_FFF9;
    mem[8] = 64'd5;
    mem[9] = 64'd1;
    repeat (3) @(negedge clk);
    // R11 during reset
    check(issue_ready && !busy && !mem_req && !done && !rd_we && !illegal, "R11 in reset",
          {58'd0, issue_ready, busy, mem_req, done, rd_we, illegal}, 64'h20);
    rst_n = 1'b1;
    @(negedge clk);
    check(issue_ready && !busy && !mem_req && !done, "R11 after reset",
          {60'd0, issue_ready, busy, mem_req, done}, 64'h8);

    do_amo(5'b00001, 5'd10, 1, 64'hDEAD_BEEF_0000_1234, "R6 swap");
    stall_cfg = 1; rsp_cfg = 2;
    do_amo(5'b00000, 5'd11, 2, 64'd2, "R6 add wrap");
    do_amo(5'b00100, 5'd12, 3, 64'h0F0F_0F0F_0F0F_0F0F, "R7 xor");
    stall_cfg = 0; rsp_cfg = 0;
    do_amo(5'b01100, 5'd13, 4, 64'h00FF_00FF_00FF_00FF, "R7 and");
    do_amo(5'b01000, 5'd14, 5, 64'h8000_0000_0000_0001, "R7 or");
    do_amo(5'b10000, 5'd15, 6, 64'hFFFF_FFFF_FFFF_FFFD, "R8 min signed");
    do_amo(5'b10100, 5'd16, 7, 64'd2, "R8 max signed");
    stall_cfg = 3; rsp_cfg = 1;
    do_amo(5'b11000, 5'd17, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R9 minu");
    do_amo(5'b11100, 5'd18, 9, 64'h8000_0000_0000_0000, "R9 maxu");
    do_amo(5'b10000, 5'd19, 9, 64'd7, "R8 min signed negative old");
    do_amo(5'b00000, 5'd0, 10, 64'd100, "R5 rd zero");
    do_amo(5'b00001, 5'd20, 11, 64'h55, "R12 hints set", 2'b11);
    do_amo(5'b00010, 5'd21, 12, 64'h77, "R10 code 00010");
    do_amo(5'b11111, 5'd22, 13, 64'h77, "R10 code 11111");

    // R2: offer held across the busy window is taken once
    stall_cfg = 2; rsp_cfg = 2;
    do_amo(5'b00000, 5'd23, 14, 64'd1, "R2 held offer", 2'b00, 1);
    issue_valid = 1'b1;
    @(negedge clk);
    check(busy && !issue_ready, "R2 busy while held", {62'd0, busy, issue_ready}, 64'h2);
    @(negedge clk);
    issue_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    check(mem[14] == 64'h1111_0000_0000_000F, "R2 single application", mem[14], 64'h1111_0000_0000_000F);

    // R1: non-matching opcode and width are ignored
    repeat (2) @(negedge clk);
    begin
      int dc;
      dc = done_count;
      gnt_count = 0;
      instr = {5'b00001, 2'b00, 5'd7, 5'd3, 3'b011, 5'd9, 7'b0110011};
      rs1_val = BASE | (64'd15 << 3);
      rs2_val = 64'h99;
      issue_valid = 1'b1;
      @(negedge clk);
      instr = {5'b00001, 2'b00, 5'd7, 5'd3, 3'b010, 5'd9, 7'b0101111};
      @(negedge clk);
      issue_valid = 1'b0;
      repeat (6) @(negedge clk);
      check(!busy && issue_ready, "R1 stays idle", {62'd0, busy, issue_ready}, 64'h1);
      check(gnt_count == 0, "R1 no memory access", 64'(gnt_count), 64'd0);
      check(done_count == dc, "R1 no completion", 64'(done_count), 64'(dc));
      check(mem[15] == 64'h1111_0000_0000_000F, "R1 memory untouched", mem[15], 64'h1111_0000_0000_000F);
    end

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R12 all operations completed", 64'(q.size()), 64'd0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule